// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a single activity line driven by a processor and raises a one-cycle expiry strobe when that line has shown no transition for a programmed number of clock cycles. Rising and falling transitions both count as activity. A processor that is still running keeps the line toggling, so the timer never runs out. The line is asynchronous to the block clock. It passes through a synchronizer, and transitions are found by comparing successive synchronized samples.

The expiry strobe goes to a reset generator. The generator stretches the strobe into a timed reset pulse and reports back through a reset-asserted flag. While that flag is high the timer is held at zero. After a strobe, the timer waits until the reset generator has responded before it counts again. A line that stays stuck therefore produces one strobe per timeout, with a reset pulse between each pair of strobes. An enable input turns the whole function off. All pins are plain control signals: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `wdk_monitor`

## Requirements
- R1: While `rst_n` is low, `wd_expire` is 0 and the timer is cleared. With a constant line after release, the first strobe appears exactly TIMEOUT_CYCLES clock edges after release.
- R2: A rising transition on `wd_kick` restarts the timer. The next strobe appears TIMEOUT_CYCLES+3 clock edges after the transition is applied: two synchronizer stages plus one edge-detect stage, then the full count.
- R3: A falling transition on `wd_kick` restarts the timer, with the same latency as in R2.
- R4: If the line stays quiet for TIMEOUT_CYCLES counted clock edges, a strobe is produced. The strobe is registered and follows the cycle in which the count reached TIMEOUT_CYCLES-1.
- R5: `wd_expire` is high for exactly one clock cycle per expiry.
- R6: While `sys_rst_active` is high, no strobe is produced and the timer stays at zero. After the flag falls, a quiet line gives the next strobe exactly TIMEOUT_CYCLES edges later.
- R7: After a strobe, no further strobe is produced, and transitions on `wd_kick` have no effect, until `sys_rst_active` has been seen high. A stuck line therefore produces periodic strobes, each separated by a reset pulse.
- R8: A pulse on `wd_kick` only one clock cycle wide counts as activity. Its trailing edge restarts the timer, so the next strobe appears TIMEOUT_CYCLES+4 edges after the pulse starts.
- R9: While `wd_enable` is low, the timer is held at zero and no strobe is produced. This also leaves the post-strobe wait of R7. After `wd_enable` rises, a quiet line gives a strobe exactly TIMEOUT_CYCLES edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_kick | input | 1 | Asynchronous activity line from the processor |
| wd_enable | input | 1 | High enables the watchdog function |
| sys_rst_active | input | 1 | High while the reset generator is asserting system reset |
| wd_expire | output | 1 | One-cycle strobe when the timeout expires |

## Verification
The hardest situation to reach from the ports is the post-strobe wait with no reset response. The reset generator normally answers a strobe at once, so edges arriving while the timer is parked are never seen. The bench therefore contains its own reset generator model, which can be switched off. With it off, the bench lets a strobe fire, toggles the line repeatedly while the generator stays silent, and then raises the reset flag by hand, measuring the cycles to the next strobe. The randomized phase keeps the generator on and varies its pulse length, the gaps between kicks and short enable drops. A cycle-level reference compares every cycle.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_WAIT = 1'b1
  } wd_state_e;

  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/wdk_edge.sv
module wdk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic any_edge
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  // rising or falling both qualify
  assign any_edge = level ^ level_d;
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
  import wdk_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  localparam int CW = cnt_width(TIMEOUT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rst_active,
  input  logic          kick_edge,
  output logic          expire,
  output logic [CW-1:0] count,
  output logic          waiting
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES - 1);

  wd_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      state  <= WD_RUN;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!enable) begin
        count <= '0;
        state <= WD_RUN;
      end else begin
        case (state)
          WD_WAIT: begin
            count <= '0;
            if (rst_active) state <= WD_RUN;
          end
          default: begin
            if (rst_active || kick_edge) begin
              count <= '0;
            end else if (count == LIMIT) begin
              count  <= '0;
              expire <= 1'b1;
              state  <= WD_WAIT;
            end else begin
              count <= count + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign waiting = (state == WD_WAIT);
endmodule

// File: rtl/wdk_monitor.sv
module wdk_monitor
  import wdk_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int SYNC_STAGES    = 2,
  localparam int CW = cnt_width(TIMEOUT_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_kick,
  input  logic wd_enable,
  input  logic sys_rst_active,
  output logic wd_expire
);
  logic          kick_sync;
  logic          kick_edge;
  logic [CW-1:0] tmr_count;
  logic          tmr_wait;

  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (wd_kick),
    .d_sync  (kick_sync)
  );

  wdk_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (kick_sync),
    .any_edge (kick_edge)
  );

  wdk_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (wd_enable),
    .rst_active (sys_rst_active),
    .kick_edge  (kick_edge),
    .expire     (wd_expire),
    .count      (tmr_count),
    .waiting    (tmr_wait)
  );
endmodule

// File: rtl/wdk_monitor_chk.sv
module wdk_monitor_chk #(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int CW = 27
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          rst_active,
  input logic          expire,
  input logic          kick_edge,
  input logic [CW-1:0] count,
  input logic          waiting
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R5
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!expire && count == '0)); // R9
  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (!expire && count == '0)); // R6
  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge |=> (count == '0)); // R2
  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(count) == CW'(TIMEOUT_CYCLES - 1))); // R4
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !rst_active) |=> !expire); // R7
endmodule

bind wdk_monitor wdk_monitor_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (wd_enable),
  .rst_active (sys_rst_active),
  .expire     (wd_expire),
  .kick_edge  (kick_edge),
  .count      (tmr_count),
  .waiting    (tmr_wait)
);

// File: tb/wdk_monitor_test.sv
module wdk_monitor_test;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic enable = 1'b0;
  logic rst_active = 1'b0;
  logic expire;

  always #10 clk = ~clk;

  wdk_monitor #(.TIMEOUT_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .wd_kick(kick), .wd_enable(enable),
    .sys_rst_active(rst_active), .wd_expire(expire)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference expectation derived from the requirements
  bit m_s1, m_s2, m_last, m_wait, m_exp;
  int m_quiet;
  always @(posedge clk) begin
    bit chg, nxt;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_last = 0; m_wait = 0; m_exp = 0; m_quiet = 0;
    end else begin
      chg = (m_s2 != m_last);
      m_last = m_s2; m_s2 = m_s1; m_s1 = kick;
      nxt = 0;
      if (!enable) begin m_quiet = 0; m_wait = 0; end
      else if (m_wait) begin m_quiet = 0; if (rst_active) m_wait = 0; end
      else if (rst_active || chg) m_quiet = 0;
      else if (m_quiet == T - 1) begin nxt = 1; m_quiet = 0; m_wait = 1; end
      else m_quiet++;
      m_exp = nxt;
    end
  end

  // per-cycle comparison: R4 R5 R6 R7 R9
  always @(negedge clk)
    if (rst_n && !done)
      check(expire === m_exp, "R4/R5/R6/R7 cycle", int'(expire), int'(m_exp));

  // reset generator model
  bit gen_on = 1;
  bit manual_rst = 0;
  int gen_len = 5;
  int gen_cnt = 0;
  always @(negedge clk) begin
    if (gen_on && expire && gen_cnt == 0) gen_cnt = gen_len;
    else if (gen_cnt > 0) gen_cnt--;
    rst_active = manual_rst || (gen_cnt > 0);
  end

  task automatic wait_expire(output int n, input int maxc);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!expire && n < maxc);
  endtask

  task automatic count_strobes(output int s, input int cyc);
    s = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (expire) s++;
    end
  endtask

  initial begin
    int n, s;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    enable = 1;
    repeat (3) @(negedge clk);
    check(expire == 0, "R1 reset state", int'(expire), 0);
    rst_n = 1;
    wait_expire(n, 3 * T);
    check(n == T, "R1 first strobe after release", n, T);
    @(negedge clk);
    check(expire == 0, "R5 strobe width", int'(expire), 0);

    // stuck line: periodic strobes
    count_strobes(s, 4 * (T + 8));
    check(s >= 3, "R7 periodic strobes", s, 3);

    // disable
    @(negedge clk); enable = 0;
    count_strobes(s, 3 * T);
    check(s == 0, "R9 disabled no strobe", s, 0);
    enable = 1;
    wait_expire(n, 3 * T);
    check(n == T, "R9 full timeout after enable", n, T);
    repeat (10) @(negedge clk);

    // regular kicking keeps it quiet
    s = 0;
    repeat (6) begin
      int k;
      kick = ~kick;
      count_strobes(k, T - 5);
      s += k;
    end
    check(s == 0, "R2/R3 kicks suppress strobes", s, 0);
    kick = 1'b1;
    if (kick) begin
      wait_expire(n, 3 * T);
      check(n == T + 3, "R2 rising edge restart latency", n, T + 3);
    end
    repeat (10) @(negedge clk);
    kick = 1'b0;
    wait_expire(n, 3 * T);
    check(n == T + 3, "R3 falling edge restart latency", n, T + 3);
    repeat (10) @(negedge clk);

    // one-cycle pulse
    repeat (T - 12) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    n = 1;
    do begin @(negedge clk); n++; end while (!expire && n < 3 * T);
    check(n == T + 4, "R8 short pulse counts", n, T + 4);
    repeat (10) @(negedge clk);

    // wait state with no reset response
    gen_on = 0;
    kick = 1'b1;
    wait_expire(n, 3 * T);
    check(n == T + 3, "R7 setup strobe", n, T + 3);
    s = 0;
    repeat (4) begin
      int k;
      kick = ~kick;
      count_strobes(k, 5);
      s += k;
    end
    count_strobes(n, 2 * T);
    s += n;
    check(s == 0, "R7 edges ignored while waiting", s, 0);
    manual_rst = 1;
    count_strobes(s, 2 * T);
    check(s == 0, "R6 no strobe while reset held", s, 0);
    manual_rst = 0;
    wait_expire(n, 3 * T);
    check(n == T, "R6 restart after reset release", n, T);
    repeat (10) @(negedge clk);
    manual_rst = 1;
    repeat (3) @(negedge clk);
    manual_rst = 0;
    gen_on = 1;

    // constrained random phase
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      gen_len = int'($urandom_range(2, 12));
      if (sel == 0) enable = 1'b0;
      else if (sel < 6) kick = ~kick;
      else enable = 1'b1;
      repeat ($urandom_range(1, T + 20)) @(negedge clk);
      enable = 1'b1;
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule